// File: doc/BRIEF.md
# Parallel Port Host Register Block

This block is the host-facing register set of a PC-style parallel port that also carries an extended control register. Host software issues byte-wide reads and writes on an 11-bit offset. The low offsets reach the output data latch, the status byte, the control byte and two byte latches for address and data transfers. The upper group, starting at 0x400, reaches a FIFO port, a fixed configuration byte and the extended control register.

The block drives the eight data pins. A direction bit in the control register can turn those drivers off, and data reads then return the levels seen on the pins. A 16-byte FIFO is filled and drained through the FIFO port while the mode field selects FIFO test mode. The FIFO's empty and full flags read back in the extended control register. A sticky timeout flag in the status byte is set by a pulse on an input and cleared by software.

Probe software relies on this exact readback to tell the port apart from a plain port, so every field is fixed to the cycle. Read data is combinational from the current address and state. Writes and FIFO pops take effect at the rising clock edge.

Top module: `ppreg_host`

## Requirements
- R1: After reset the control register reads 0x0C, the extended control register reads 0x01 (mode 000, FIFO empty), the data latch reads 0x00 and the data drivers are enabled.
- R2: Offset 0 holds the output data byte, which drives the data pins. Offsets 3 and 4 are separate byte latches that read back the last value written to them.
- R3: Control register bits 7:6 always read as 0, and writing them has no effect. Control bits 3:0 drive the four control pins.
- R4: While control bit 5 is 1 the data pin drivers are off and a read of offset 0 returns the pin levels. While it is 0 the drivers are on and offset 0 returns the latched byte.
- R5: Extended control register layout: bits 7:5 are the mode, bits 4:2 are writable storage, bit 1 is the FIFO full flag and bit 0 is the FIFO empty flag. Bits 1:0 are read-only, so a write of 0x34 to an empty port reads back 0x35.
- R6: A control write never changes the extended control register, and a write to the extended control register never changes the control register.
- R7: In FIFO test mode (mode 110), a write to offset 0x400 stores the byte, and the empty flag reads 0 from the next cycle on.
- R8: The FIFO holds 16 bytes and is read in write order. Once it holds 16 bytes the full flag reads 1, and a further write is dropped.
- R9: A FIFO read while the FIFO is empty returns the last byte read. Outside FIFO test mode, writes and reads at 0x400 neither store nor remove bytes.
- R10: Status bit 0 is set by a one-cycle pulse on `epp_timeout` and cleared by a status write with bit 0 = 1. A write with bit 0 = 0 leaves it unchanged, and a pulse in the same cycle as a clearing write leaves it set.
- R11: Offset 0x401 reads the constant `CFGB_VALUE` (default 0x14), and writes to it are ignored.
- R12: Status bits 7:3 show `status_pins[4:0]`, bits 2:1 read 0, and any other offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 11 | Register offset |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rd | input | 1 | Read strobe (pops the FIFO at 0x400) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current offset |
| pins_in | input | 8 | Levels sensed on the data pins |
| pins_out | output | 8 | Data pin output value |
| pins_oe | output | 1 | Data pin driver enable |
| ctrl_pins | output | 4 | Control pin outputs (control bits 3:0) |
| status_pins | input | 5 | Peripheral status lines shown in status bits 7:3 |
| epp_timeout | input | 1 | One-cycle timeout event |

## Verification
The bench compares read data, data pins, driver enable and control pins against a behavioural model every cycle, so every register stays under check throughout the run. The direction bit is exercised with two different pin patterns, so a read that returns the latch instead of the pins is caught. The extended control register is written with 0x34 and with all ones, which exposes any read-only flag that can be overwritten. Interleaved control and extended-control writes catch aliasing between the two registers. FIFO traffic runs past full and past empty, which separates dropped writes, write order and the last-read fallback. Timeout pulses are tried against clearing writes, non-clearing writes and a pulse in the same cycle as a clearing write.

// File: rtl/ppreg_pkg.sv
package ppreg_pkg;

  localparam int OFF_DATA = 'h000;
  localparam int OFF_STAT = 'h001;
  localparam int OFF_CTRL = 'h002;
  localparam int OFF_XADR = 'h003;
  localparam int OFF_XDAT = 'h004;
  localparam int OFF_FIFO = 'h400;
  localparam int OFF_CFGB = 'h401;
  localparam int OFF_ECR  = 'h402;

  typedef enum logic [2:0] {
    MODE_STD       = 3'b000,
    MODE_BIDIR     = 3'b001,
    MODE_FIFO_FWD  = 3'b010,
    MODE_EXT       = 3'b011,
    MODE_RSV       = 3'b100,
    MODE_XFER      = 3'b101,
    MODE_FIFO_TEST = 3'b110,
    MODE_CFG       = 3'b111
  } port_mode_e;

  typedef struct packed {
    logic data;
    logic stat;
    logic ctrl;
    logic xadr;
    logic xdat;
    logic fifo;
    logic cfgb;
    logic ecr;
  } reg_sel_t;

  function automatic logic [7:0] ecr_pack(input port_mode_e mode, input logic [2:0] mid,
                                          input logic full, input logic empty);
    return {mode, mid, full, empty};
  endfunction

  function automatic logic [7:0] ctrl_pack(input logic [5:0] c);
    return {2'b00, c};
  endfunction

  function automatic logic [7:0] stat_pack(input logic [4:0] lines, input logic tmo);
    return {lines, 2'b00, tmo};
  endfunction

endpackage

// File: rtl/ppreg_decode.sv
module ppreg_decode
  import ppreg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel = '0;
    case (addr)
      ADDR_W'(OFF_DATA): sel.data = 1'b1;
      ADDR_W'(OFF_STAT): sel.stat = 1'b1;
      ADDR_W'(OFF_CTRL): sel.ctrl = 1'b1;
      ADDR_W'(OFF_XADR): sel.xadr = 1'b1;
      ADDR_W'(OFF_XDAT): sel.xdat = 1'b1;
      ADDR_W'(OFF_FIFO): sel.fifo = 1'b1;
      ADDR_W'(OFF_CFGB): sel.cfgb = 1'b1;
      ADDR_W'(OFF_ECR):  sel.ecr  = 1'b1;
      default:           sel      = '0;
    endcase
  end
endmodule

// File: rtl/ppreg_fifo.sv
module ppreg_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         push_ok,
  output logic         pop_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (full && $stable(cnt)));
  a_r7_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !empty);
  a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> empty);
endmodule

// File: rtl/ppreg_tmo.sv
module ppreg_tmo (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_pulse,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (tmo_pulse) flag <= 1'b1;
    else if (clr_req)   flag <= 1'b0;
  end

  a_r10_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> flag);
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !tmo_pulse) |=> !flag);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/ppreg_host.sv
module ppreg_host
  import ppreg_pkg::*;
#(
  parameter int         ADDR_W     = 11,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CFGB_VALUE = 8'h14,
  parameter logic [5:0] CTRL_RESET = 6'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        pins_in,
  output logic [7:0]        pins_out,
  output logic              pins_oe,
  output logic [3:0]        ctrl_pins,
  input  logic [4:0]        status_pins,
  input  logic              epp_timeout
);
  localparam int DIR_BIT = 5;

  reg_sel_t   sel;
  logic [7:0] data_q, xadr_q, xdat_q, last_rd_q;
  logic [5:0] ctrl_q;
  port_mode_e mode_q;
  logic [2:0] mid_q;

  logic wr_data, wr_ctrl, wr_xadr, wr_xdat, wr_ecr, wr_stat;
  logic fifo_test, push_req, pop_req;
  logic fifo_empty, fifo_full, push_ok, pop_ok, tmo_flag;
  logic [7:0] fifo_head, fifo_view, ecr_view;

  ppreg_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(host_addr), .sel(sel));

  assign wr_data   = host_wr && sel.data;
  assign wr_ctrl   = host_wr && sel.ctrl;
  assign wr_xadr   = host_wr && sel.xadr;
  assign wr_xdat   = host_wr && sel.xdat;
  assign wr_ecr    = host_wr && sel.ecr;
  assign wr_stat   = host_wr && sel.stat;
  assign fifo_test = (mode_q == MODE_FIFO_TEST);
  assign push_req  = host_wr && sel.fifo && fifo_test;
  assign pop_req   = host_rd && sel.fifo && fifo_test;

  ppreg_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(host_wdata), .pop_req(pop_req),
    .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  ppreg_tmo u_tmo (
    .clk(clk), .rst_n(rst_n), .tmo_pulse(epp_timeout),
    .clr_req(wr_stat && host_wdata[0]), .flag(tmo_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      ctrl_q    <= CTRL_RESET;
      xadr_q    <= '0;
      xdat_q    <= '0;
      mode_q    <= MODE_STD;
      mid_q     <= '0;
      last_rd_q <= '0;
    end else begin
      if (wr_data) data_q <= host_wdata;
      if (wr_ctrl) ctrl_q <= host_wdata[5:0];
      if (wr_xadr) xadr_q <= host_wdata;
      if (wr_xdat) xdat_q <= host_wdata;
      if (wr_ecr) begin
        mode_q <= port_mode_e'(host_wdata[7:5]);
        mid_q  <= host_wdata[4:2];
      end
      if (pop_ok) last_rd_q <= fifo_head;
    end
  end

  assign fifo_view = fifo_empty ? last_rd_q : fifo_head;
  assign ecr_view  = ecr_pack(mode_q, mid_q, fifo_full, fifo_empty);
  assign pins_out  = data_q;
  assign pins_oe   = !ctrl_q[DIR_BIT];
  assign ctrl_pins = ctrl_q[3:0];

  always_comb begin
    host_rdata = 8'h00;
    if (sel.data)      host_rdata = ctrl_q[DIR_BIT] ? pins_in : data_q;
    else if (sel.stat) host_rdata = stat_pack(status_pins, tmo_flag);
    else if (sel.ctrl) host_rdata = ctrl_pack(ctrl_q);
    else if (sel.xadr) host_rdata = xadr_q;
    else if (sel.xdat) host_rdata = xdat_q;
    else if (sel.fifo) host_rdata = fifo_view;
    else if (sel.cfgb) host_rdata = CFGB_VALUE;
    else if (sel.ecr)  host_rdata = ecr_view;
  end

  a_r6_ctrl_keeps_ecr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> $stable(ecr_view));
  a_r6_ecr_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ecr |=> $stable(ctrl_pins) && $stable(pins_oe));
  a_r4_dir_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && host_wdata[DIR_BIT]) |=> !pins_oe);
  a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_test && !push_ok && !pop_ok) |=> $stable(fifo_empty) && $stable(fifo_full));
endmodule

// File: tb/sim_ppreg_host.sv
module sim_ppreg_host;
  localparam logic [7:0] CFGB = 8'h14;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0, epp_timeout = 1'b0;
  logic [7:0] host_wdata = '0, pins_in = '0;
  logic [4:0] status_pins = '0;
  logic [7:0] host_rdata, pins_out;
  logic pins_oe;
  logic [3:0] ctrl_pins;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_data = 0, m_xa = 0, m_xd = 0, m_last = 0;
  logic [5:0] m_ctrl = 6'h0C;
  logic [2:0] m_mode = 0, m_mid = 0;
  bit m_to = 0;
  logic [7:0] q[$];

  always #5 clk = ~clk;

  ppreg_host u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe),
    .ctrl_pins(ctrl_pins), .status_pins(status_pins), .epp_timeout(epp_timeout)
  );

  function automatic logic [7:0] exp_read(input logic [10:0] a);
    case (a)
      11'h000: return m_ctrl[5] ? pins_in : m_data;
      11'h001: return {status_pins, 2'b00, m_to};
      11'h002: return {2'b00, m_ctrl};
      11'h003: return m_xa;
      11'h004: return m_xd;
      11'h400: return (q.size() > 0) ? q[0] : m_last;
      11'h401: return CFGB;
      11'h402: return {m_mode, m_mid, q.size() == DEPTH, q.size() == 0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic [10:0] a, input bit w, input bit r, input logic [7:0] d,
                    input bit tp, input string req);
    bit was_full, was_empty;
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d; epp_timeout = tp;
    #1;
    check(req, "rdata", host_rdata, exp_read(a));
    check(req, "pins_out", pins_out, m_data);
    check(req, "pins_oe", {7'd0, pins_oe}, {7'd0, !m_ctrl[5]});
    check(req, "ctrl_pins", {4'd0, ctrl_pins}, {4'd0, m_ctrl[3:0]});
    was_full = (q.size() == DEPTH);
    was_empty = (q.size() == 0);
    if (tp) m_to = 1;
    else if (w && a == 11'h001 && d[0]) m_to = 0;
    if (r && a == 11'h400 && m_mode == 3'b110 && !was_empty) m_last = q.pop_front();
    if (w) begin
      case (a)
        11'h000: m_data = d;
        11'h002: m_ctrl = d[5:0];
        11'h003: m_xa = d;
        11'h004: m_xd = d;
        11'h402: begin m_mode = d[7:5]; m_mid = d[4:2]; end
        11'h400: if (m_mode == 3'b110 && !was_full) q.push_back(d);
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [10:0] a, input string req);
    op(a, 0, 1, 8'h00, 0, req);
  endtask
  task automatic wr(input logic [10:0] a, input logic [7:0] d, input string req);
    op(a, 1, 0, d, 0, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 200000) begin
      fails++;
      $display("FAIL watchdog actual %0d expected <200000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    status_pins = 5'h15;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    rd(11'h002, "R1"); rd(11'h402, "R1"); rd(11'h000, "R1");
    // R12 status lines and unmapped offset
    rd(11'h001, "R12"); status_pins = 5'h0A; rd(11'h001, "R12"); rd(11'h123, "R12");
    // R2 low latches
    wr(11'h000, 8'h5A, "R2"); rd(11'h000, "R2");
    wr(11'h003, 8'h33, "R2"); wr(11'h004, 8'hC3, "R2");
    rd(11'h003, "R2"); rd(11'h004, "R2");
    // R3 unused control bits
    wr(11'h002, 8'hC7, "R3"); rd(11'h002, "R3");
    wr(11'h002, 8'hCC, "R3"); rd(11'h002, "R3");
    // R4 direction
    pins_in = 8'hA5; wr(11'h002, 8'h2C, "R4"); rd(11'h000, "R4");
    pins_in = 8'h3C; rd(11'h000, "R4");
    wr(11'h002, 8'h0C, "R4"); rd(11'h000, "R4");
    // R5 extended control layout
    wr(11'h402, 8'h34, "R5"); rd(11'h402, "R5");
    wr(11'h402, 8'hFF, "R5"); rd(11'h402, "R5");
    // R6 no aliasing
    wr(11'h402, 8'h34, "R6"); wr(11'h002, 8'h0E, "R6"); rd(11'h402, "R6");
    wr(11'h402, 8'h20, "R6"); rd(11'h002, "R6");
    // R9 fifo port ignored outside test mode
    wr(11'h400, 8'h11, "R9"); rd(11'h402, "R9"); rd(11'h400, "R9");
    // R7 test mode push
    wr(11'h402, 8'hC0, "R7"); rd(11'h402, "R7");
    wr(11'h400, 8'hAA, "R7"); rd(11'h402, "R7");
    // R8 fill, overflow, drain in order
    for (int i = 1; i < DEPTH; i++) wr(11'h400, 8'(8'h40 + i), "R8");
    rd(11'h402, "R8");
    wr(11'h400, 8'h99, "R8"); rd(11'h402, "R8");
    for (int i = 0; i < DEPTH; i++) rd(11'h400, "R8");
    rd(11'h402, "R8");
    // R9 empty read returns last value
    rd(11'h400, "R9"); rd(11'h400, "R9");
    wr(11'h402, 8'h00, "R9"); wr(11'h400, 8'h77, "R9"); rd(11'h402, "R9");
    // R10 timeout flag
    op(11'h000, 0, 0, 8'h00, 1, "R10"); rd(11'h001, "R10");
    wr(11'h001, 8'hFE, "R10"); rd(11'h001, "R10");
    wr(11'h001, 8'h01, "R10"); rd(11'h001, "R10");
    op(11'h001, 1, 0, 8'h01, 1, "R10"); rd(11'h001, "R10");
    // R11 fixed configuration byte
    rd(11'h401, "R11"); wr(11'h401, 8'hFF, "R11"); rd(11'h401, "R11");
    rd(11'h002, "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule